// File: doc/BRIEF.md
# Horizontal Inset Scaler with Pixel Replication

This block resizes a picture-in-picture inset along the horizontal axis. On the capture side it keeps a fraction of the incoming pixel stream. A 6-bit reduction value N selects the ratio N/96. A phase accumulator decides which pixels survive. When N is zero the inset is switched off and no pixels are written.

On the display side the block takes stored pixels through a valid/ready handshake. It repeats each one for one, two or four consecutive output cycles. Repetition is stretched where the inset is shown in replay form, and doubled where the main window is enlarged. The block also produces a line-advance pulse, which tells the memory reader when to move on to the next stored line. When vertical doubling is on, this pulse comes on every second line, so each line is shown twice.

A field-start input restarts the line pairing and the decimation phase. A line-start input on the capture side restarts the decimation phase for each line.

Top module: `insetHScaler`

## Requirements
- R1: During and straight after reset, `wrValid`, `outValid` and `lineAdvance` are low and `dispInReady` is high.
- R2: The capture side keeps a 7-bit phase. For each pixel with `inValid` high, it adds the reduction value N. When the sum is 96 or more, it subtracts 96 and presents that pixel on `wrPixel` with `wrValid` high one cycle later. With N=48, every second pixel of a line is kept, starting with the second.
- R3: When `redN` is 0, `wrValid` stays low whatever the input.
- R4: Reduction values from 49 to 63 behave exactly as 48.
- R5: A pulse on `inLineStart` or `fieldStart` clears the phase before the pixel of the same cycle is counted. Every line therefore starts with the same decimation pattern.
- R6: With `mainSel`=0, the 2-bit code `hExpCode` sets the number of output cycles per stored pixel: 01 gives 2, 11 gives 4, and 00 or 10 give 1. `dispInReady` is low for all but the last of those cycles.
- R7: With `mainSel`=1, `hExpCode` is ignored. Each stored pixel is shown for 2 cycles when `mainDouble` is 1, or for 1 cycle when it is 0.
- R8: `lineAdvance` pulses one cycle after `dispLineStart`. With `vExp`=0 it pulses after every line start. With `vExp`=1 it pulses only after the 2nd, 4th, … line start since the last `fieldStart`.
- R9: A pixel accepted at an edge appears on `outPixel` with `outValid` high right after that edge. The repetition factor is fixed at acceptance. When no new pixel arrives, `outValid` falls after the last repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| redN | input | 6 | Horizontal reduction numerator N (ratio N/96) |
| hExpCode | input | 2 | Inset horizontal expansion code |
| vExp | input | 1 | Vertical line doubling enable |
| mainSel | input | 1 | 1: display stream is the main window |
| mainDouble | input | 1 | Main-window horizontal doubling |
| fieldStart | input | 1 | Field start pulse |
| inLineStart | input | 1 | Capture-side line start pulse |
| inValid | input | 1 | Capture pixel strobe |
| inPixel | input | PIX_W | Capture pixel |
| wrValid | output | 1 | Kept pixel strobe toward memory |
| wrPixel | output | PIX_W | Kept pixel |
| dispInValid | input | 1 | Stored pixel available |
| dispInPixel | input | PIX_W | Stored pixel |
| dispInReady | output | 1 | Block accepts a stored pixel |
| dispLineStart | input | 1 | Display-side line start pulse |
| lineAdvance | output | 1 | Move the memory reader to the next stored line |
| outValid | output | 1 | Display pixel strobe |
| outPixel | output | PIX_W | Display pixel |

## Verification
A corrupted decimation phase shows up within one line. It moves the index of the first kept pixel and changes the number of `wrValid` strobes per line. Both are visible one cycle after the offending input pixel.

A wrong repeat count on the display side shows up at once as a wrong `dispInReady` pattern and a wrong `outPixel` sequence within one stored pixel's span of at most four cycles. A wrong line parity shows up at the next `dispLineStart`, as a missing or extra `lineAdvance` pulse.

// File: rtl/insetHScalerPkg.sv
package insetHScalerPkg;
  localparam int RED_DEN = 96;
  localparam int RED_MAX = 48;

  typedef struct packed {
    logic wrKeep;
    logic dispLoad;
  } scalerStrobe_t;
endpackage

// File: rtl/insetHScalerCtl.sv
module insetHScalerCtl
  import insetHScalerPkg::*;
#(
  parameter int RED_W = 6,
  parameter int MAX_REP = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic [RED_W-1:0] redN,
  input  logic [1:0] hExpCode,
  input  logic vExp,
  input  logic mainSel,
  input  logic mainDouble,
  input  logic fieldStart,
  input  logic inLineStart,
  input  logic inValid,
  input  logic dispInValid,
  input  logic dispLineStart,
  output logic dispInReady,
  output logic outValid,
  output logic lineAdvance,
  output scalerStrobe_t strobe
);
  localparam int ACC_W = $clog2(RED_DEN);
  localparam int SUM_W = ACC_W + 1;
  localparam int CNT_W = $clog2(MAX_REP);
  localparam int REP_W = CNT_W + 1;

  logic [ACC_W-1:0] acc, accBase, accNext;
  logic [SUM_W-1:0] accSum;
  logic [RED_W-1:0] redEff;
  logic keep;

  logic [REP_W-1:0] repFactor;
  logic [CNT_W-1:0] remain;
  logic holdValid;
  logic dispLoad;

  logic lineParity, parityBase;

  // Capture-side phase accumulator (R2, R3, R4, R5)
  always_comb begin
    redEff  = (redN > RED_W'(RED_MAX)) ? RED_W'(RED_MAX) : redN;
    accBase = (inLineStart || fieldStart) ? '0 : acc;
    accSum  = SUM_W'(accBase) + SUM_W'(redEff);
    keep    = inValid && (redEff != '0) && (accSum >= SUM_W'(RED_DEN));
    if (!inValid)   accNext = accBase;
    else if (keep)  accNext = ACC_W'(accSum - SUM_W'(RED_DEN));
    else            accNext = ACC_W'(accSum);
  end

  always_ff @(posedge clk) begin
    if (!rstN) acc <= '0;
    else       acc <= accNext;
  end

  // Display-side repeat factor (R6, R7)
  always_comb begin
    if (mainSel) begin
      repFactor = mainDouble ? REP_W'(2) : REP_W'(1);
    end else begin
      case (hExpCode)
        2'b01:   repFactor = REP_W'(2);
        2'b11:   repFactor = REP_W'(MAX_REP);
        default: repFactor = REP_W'(1);
      endcase
    end
  end

  assign dispInReady = !holdValid || (remain == '0);
  assign dispLoad    = dispInValid && dispInReady;
  assign outValid    = holdValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      remain    <= '0;
    end else if (dispLoad) begin
      holdValid <= 1'b1;
      remain    <= CNT_W'(repFactor - REP_W'(1));
    end else if (holdValid) begin
      if (remain == '0) holdValid <= 1'b0;
      else              remain    <= remain - CNT_W'(1);
    end
  end

  // Vertical line pairing (R8)
  assign parityBase = fieldStart ? 1'b0 : lineParity;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineParity  <= 1'b0;
      lineAdvance <= 1'b0;
    end else begin
      lineAdvance <= dispLineStart && (!vExp || parityBase);
      if (dispLineStart) lineParity <= vExp && !parityBase;
      else               lineParity <= parityBase;
    end
  end

  assign strobe.wrKeep   = keep;
  assign strobe.dispLoad = dispLoad;
endmodule

// File: rtl/insetHScalerDp.sv
module insetHScalerDp
  import insetHScalerPkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  scalerStrobe_t strobe,
  input  logic [PIX_W-1:0] inPixel,
  input  logic [PIX_W-1:0] dispInPixel,
  output logic wrValid,
  output logic [PIX_W-1:0] wrPixel,
  output logic [PIX_W-1:0] outPixel
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrValid  <= 1'b0;
      wrPixel  <= '0;
      outPixel <= '0;
    end else begin
      wrValid <= strobe.wrKeep;
      if (strobe.wrKeep)   wrPixel  <= inPixel;
      if (strobe.dispLoad) outPixel <= dispInPixel;
    end
  end
endmodule

// File: rtl/insetHScaler.sv
module insetHScaler
  import insetHScalerPkg::*;
#(
  parameter int PIX_W = 8,
  parameter int RED_W = 6,
  parameter int MAX_REP = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic [RED_W-1:0] redN,
  input  logic [1:0] hExpCode,
  input  logic vExp,
  input  logic mainSel,
  input  logic mainDouble,
  input  logic fieldStart,
  input  logic inLineStart,
  input  logic inValid,
  input  logic [PIX_W-1:0] inPixel,
  output logic wrValid,
  output logic [PIX_W-1:0] wrPixel,
  input  logic dispInValid,
  input  logic [PIX_W-1:0] dispInPixel,
  output logic dispInReady,
  input  logic dispLineStart,
  output logic lineAdvance,
  output logic outValid,
  output logic [PIX_W-1:0] outPixel
);
  scalerStrobe_t strobe;

  insetHScalerCtl #(.RED_W(RED_W), .MAX_REP(MAX_REP)) ctl (
    .clk(clk), .rstN(rstN), .redN(redN), .hExpCode(hExpCode), .vExp(vExp),
    .mainSel(mainSel), .mainDouble(mainDouble), .fieldStart(fieldStart),
    .inLineStart(inLineStart), .inValid(inValid), .dispInValid(dispInValid),
    .dispLineStart(dispLineStart), .dispInReady(dispInReady),
    .outValid(outValid), .lineAdvance(lineAdvance), .strobe(strobe)
  );

  insetHScalerDp #(.PIX_W(PIX_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inPixel(inPixel),
    .dispInPixel(dispInPixel), .wrValid(wrValid), .wrPixel(wrPixel),
    .outPixel(outPixel)
  );
endmodule

// File: rtl/insetHScalerChk.sv
module insetHScalerChk #(
  parameter int PIX_W = 8,
  parameter int RED_W = 6
) (
  input logic clk,
  input logic rstN,
  input logic [RED_W-1:0] redN,
  input logic vExp,
  input logic inValid,
  input logic wrValid,
  input logic dispInReady,
  input logic dispLineStart,
  input logic lineAdvance,
  input logic outValid,
  input logic [PIX_W-1:0] outPixel
);
  assert_off_silent_R3: assert property (@(posedge clk) disable iff (!rstN)
    (redN == '0) |=> !wrValid);

  assert_wr_source_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> $past(inValid));

  assert_idle_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> dispInReady);

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !dispInReady) |=> (outValid && $stable(outPixel)));

  assert_adv_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    lineAdvance |-> $past(dispLineStart));

  assert_adv_plain_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dispLineStart && !vExp) |=> lineAdvance);
endmodule

bind insetHScaler insetHScalerChk #(.PIX_W(PIX_W), .RED_W(RED_W)) chk (
  .clk(clk), .rstN(rstN), .redN(redN), .vExp(vExp), .inValid(inValid),
  .wrValid(wrValid), .dispInReady(dispInReady), .dispLineStart(dispLineStart),
  .lineAdvance(lineAdvance), .outValid(outValid), .outPixel(outPixel)
);

// File: tb/insetHScaler_test.sv
module insetHScaler_test;
  localparam int PIX_W = 8;
  localparam int NROWS = 9;
  // row: N, pixels fed, expected kept count, expected index of first kept pixel
  localparam int DEC_TAB [NROWS][4] = '{
    '{48, 8, 4, 1}, '{32, 9, 3, 2}, '{24, 8, 2, 3}, '{40, 8, 3, 2},
    '{1, 100, 1, 95}, '{0, 10, 0, -1}, '{63, 8, 4, 1},
    '{32, 2, 0, -1}, '{32, 3, 1, 2}
  };

  logic clk = 0;
  logic rstN = 0;
  logic [5:0] redN = 0;
  logic [1:0] hExpCode = 0;
  logic vExp = 0, mainSel = 0, mainDouble = 0, fieldStart = 0;
  logic inLineStart = 0, inValid = 0;
  logic [PIX_W-1:0] inPixel = 0;
  logic wrValid;
  logic [PIX_W-1:0] wrPixel;
  logic dispInValid = 0;
  logic [PIX_W-1:0] dispInPixel = 0;
  logic dispInReady;
  logic dispLineStart = 0;
  logic lineAdvance, outValid;
  logic [PIX_W-1:0] outPixel;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  insetHScaler uut (
    .clk(clk), .rstN(rstN), .redN(redN), .hExpCode(hExpCode), .vExp(vExp),
    .mainSel(mainSel), .mainDouble(mainDouble), .fieldStart(fieldStart),
    .inLineStart(inLineStart), .inValid(inValid), .inPixel(inPixel),
    .wrValid(wrValid), .wrPixel(wrPixel), .dispInValid(dispInValid),
    .dispInPixel(dispInPixel), .dispInReady(dispInReady),
    .dispLineStart(dispLineStart), .lineAdvance(lineAdvance),
    .outValid(outValid), .outPixel(outPixel)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic decRow(input int row);
    int n, k, expCnt, expFirst, cnt, first, firstPix;
    string tag;
    n = DEC_TAB[row][0]; k = DEC_TAB[row][1];
    expCnt = DEC_TAB[row][2]; expFirst = DEC_TAB[row][3];
    tag = (n == 0) ? "R3" : (n > 48) ? "R4" : (row == NROWS - 1) ? "R5" : "R2";
    cnt = 0; first = -1; firstPix = -1;
    redN = 6'(n);
    for (int i = 0; i < k; i++) begin
      inValid = 1; inPixel = PIX_W'(i); inLineStart = (i == 0);
      step();
      if (wrValid) begin
        cnt++;
        if (first < 0) begin first = i; firstPix = int'(wrPixel); end
      end
    end
    inValid = 0; inLineStart = 0;
    check(cnt == expCnt, {tag, " kept count"}, cnt, expCnt);
    check(first == expFirst && (first < 0 || firstPix == first),
          {tag, " first kept index"}, first, expFirst);
  endtask

  task automatic dispRun(input string tag, input logic [1:0] code, input logic msel,
                         input logic mdbl, input int f);
    int p, bad, badK, gotPix, expPix;
    logic rdy;
    hExpCode = code; mainSel = msel; mainDouble = mdbl;
    p = 0; bad = 0; badK = -1; gotPix = 0; expPix = 0;
    dispInValid = 1; dispInPixel = PIX_W'(8'hA0);
    for (int k = 0; k < 3 * f; k++) begin
      rdy = dispInReady;
      step();
      if (rdy && dispInValid) begin
        p++;
        dispInPixel = PIX_W'(8'hA0 + p);
        if (p == 3) dispInValid = 0;
      end
      if (!outValid || int'(outPixel) != 8'hA0 + k / f ||
          dispInReady != ((k % f) == f - 1)) begin
        if (bad == 0) begin badK = k; gotPix = int'(outPixel); expPix = 8'hA0 + k / f; end
        bad++;
      end
    end
    check(bad == 0, {tag, " repeat sequence"}, gotPix, expPix);
    if (bad != 0) $display("  first mismatch at output cycle %0d", badK);
    step();
    check(!outValid && dispInReady, "R9 drain after last repeat", int'(outValid), 0);
  endtask

  task automatic lineRun(input logic ve);
    vExp = ve;
    fieldStart = 1; step(); fieldStart = 0; step();
    for (int n = 0; n < 4; n++) begin
      dispLineStart = 1; step(); dispLineStart = 0;
      check(lineAdvance == (!ve || (n % 2 == 1)), "R8 line advance",
            int'(lineAdvance), int'(!ve || (n % 2 == 1)));
      step();
      check(lineAdvance == 0, "R8 single pulse", int'(lineAdvance), 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 0;
    step(); step();
    check(!wrValid && !outValid && !lineAdvance && dispInReady, "R1 in reset",
          int'({wrValid, outValid, lineAdvance, dispInReady}), 1);
    rstN = 1;
    step();
    check(!wrValid && !outValid && !lineAdvance && dispInReady, "R1 after reset",
          int'({wrValid, outValid, lineAdvance, dispInReady}), 1);

    for (int r = 0; r < NROWS; r++) decRow(r);

    // R5: field start also restarts the phase
    redN = 6'd32;
    inValid = 1; inLineStart = 1; inPixel = 0; step(); inLineStart = 0;
    inPixel = 1; step();
    fieldStart = 1; inPixel = 2; step(); fieldStart = 0;
    check(!wrValid, "R5 field start clears phase", int'(wrValid), 0);
    inValid = 0; step();

    dispRun("R6 code 00", 2'b00, 0, 0, 1);
    dispRun("R6 code 01", 2'b01, 0, 0, 2);
    dispRun("R6 code 10", 2'b10, 0, 0, 1);
    dispRun("R6 code 11", 2'b11, 0, 0, 4);
    dispRun("R7 main double", 2'b11, 1, 1, 2);
    dispRun("R7 main single", 2'b01, 1, 0, 1);

    lineRun(0);
    lineRun(1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule